// File: doc/BRIEF.md
# Pipeline Interlock and Bubble Controller

This block is the hazard control unit of a five-stage in-order integer pipeline: fetch, decode, execute, memory access and writeback. It has no forwarding network. Each cycle it checks whether the instruction in decode reads a register that an older instruction in execute or memory access is still going to write. If so, it freezes the program counter and the fetch/decode register and sends an all-zero no-op into execute in place of the held instruction. The decode instruction is held until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a producer in writeback needs no stall.

The block also handles an exception raised by the instruction in execute. Stalling at that point would never end, so the unit turns the faulting instruction and all younger ones into no-ops that drain with no effect on registers or memory. It also raises a single-cycle redirect to fetch. The exception flush wins over any data-hazard stall in the same cycle. A taken branch never causes a flush, so the delay-slot instruction always executes.

The block passes the decode instruction word and its write enables towards execute, and the execute-stage write enables towards memory access. It gates both with its own controls, so the rest of the pipeline sees bubbles and killed instructions through ordinary data.

Top module: `hz_interlock_ctrl`

## Requirements
- R1: When a used, nonzero decode source equals the destination of a valid, register-writing instruction in execute or memory access, and no exception is raised, `pc_hold_o`, `ifid_hold_o` and `idex_bubble_o` are all 1 in that same cycle.
- R2: A match against an instruction that has reached writeback causes no stall. An instruction that reads the result of the instruction directly before it therefore gets exactly two bubbles, and it enters execute in cycle 6 when the producer is fetched in cycle 1.
- R3: A source equal to register 0, or a source whose use flag is 0, never causes a stall.
- R4: When `idex_bubble_o` is 1, `idex_instr_o` is all zero and `idex_rwen_o` and `idex_mwen_o` are 0. Otherwise these outputs equal the decode inputs.
- R5: While `ex_exc_i` is 1, `ex_rwen_o`, `ex_mwen_o` are 0 and `ifid_flush_o`, `idex_bubble_o` are 1. Otherwise the execute write enables pass through unchanged. No instruction younger than the faulting one writes a register or memory.
- R6: While `ex_exc_i` is 1, `pc_hold_o` and `ifid_hold_o` are 0, even when a data hazard is present.
- R7: `redirect_o` is 1 only in the first cycle of an exception (`ex_exc_i` high after a cycle or reset with it low), and is never 1 in two consecutive cycles.
- R8: `ifid_flush_o` is 0 whenever `ex_exc_i` is 0. In particular, the instruction after a branch (opcode field bits 31:26 = 6'h04 in the bench encoding) reaches execute one cycle after the branch.
- R9: After reset with all inputs at 0, every control output is 0.
- R10: A sequence with no register dependency between instructions within two of each other never stalls. This includes stores (opcode 6'h2b) and branches. The bench encoding places sources in bits 25:21 and 20:16, the destination in bits 15:11, and opcode 0 means a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| id_instr_i | input | INSTR_W | Instruction word in decode |
| id_rwen_i | input | 1 | Decode instruction writes a register |
| id_mwen_i | input | 1 | Decode instruction writes memory |
| id_src_i | input | NUM_SRC*REG_W | Decode source register numbers, source 0 in the low bits |
| id_src_use_i | input | NUM_SRC | Per-source flag: the source is actually read |
| ex_dst_i | input | REG_W | Destination register of the execute instruction |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_rwen_i | input | 1 | Execute instruction writes a register |
| ex_mwen_i | input | 1 | Execute instruction writes memory |
| mem_dst_i | input | REG_W | Destination register of the memory-access instruction |
| mem_valid_i | input | 1 | Memory-access stage holds a real instruction |
| mem_rwen_i | input | 1 | Memory-access instruction writes a register |
| ex_exc_i | input | 1 | Exception raised by the execute instruction |
| pc_hold_o | output | 1 | Keep the program counter |
| ifid_hold_o | output | 1 | Keep the fetch/decode register |
| ifid_flush_o | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble_o | output | 1 | Send a no-op into execute |
| idex_instr_o | output | INSTR_W | Instruction word entering execute |
| idex_rwen_o | output | 1 | Register write enable entering execute |
| idex_mwen_o | output | 1 | Memory write enable entering execute |
| ex_rwen_o | output | 1 | Gated register write enable leaving execute |
| ex_mwen_o | output | 1 | Gated memory write enable leaving execute |
| redirect_o | output | 1 | One-cycle fetch redirect request |

## Verification
Every control output is combinational in the stage fields and the exception flag, so the bench drives each cycle's inputs at the falling edge and compares the outputs two nanoseconds later, in the same cycle. The redirect is the only exception to this. It depends on whether the exception was already present at the previous rising edge, so the held-exception check compares the first cycle (redirect due) with the second (redirect gone). The bench models the pipeline registers around the block and updates them only from outputs sampled in the current cycle. Pipeline-level results are therefore judged at the register stage where they fall due. The dependent instruction's arrival in execute is counted in cycles from its producer's fetch. A suppressed write is judged in the cycle it would have reached writeback or memory access.

// File: rtl/hz_pkg.sv
// Shared definitions for the interlock controller.
// Assumes exactly two older stages (execute, memory access) can hold
// results not yet readable from the register file.
package hz_pkg;
    // Controller operating mode for one cycle.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_STALL = 2'd1,
        MODE_FLUSH = 2'd2
    } hz_mode_e;

    // Older stages whose destinations are compared: execute and memory access.
    localparam int NUM_OLDER = 2;
endpackage

// File: rtl/hz_src_cmp.sv
// Compares one decode source against the destinations of the older stages.
// Assumes stg_act_i already combines valid and register-write for each stage.
// Register zero and unused sources never produce a hit.
module hz_src_cmp #(
    parameter int REG_W   = 5,
    parameter int NUM_STG = 2
) (
    input  logic [REG_W-1:0]         src_i,
    input  logic                     use_i,
    input  logic [NUM_STG*REG_W-1:0] stg_dst_i,
    input  logic [NUM_STG-1:0]       stg_act_i,
    output logic                     hit_o
);
    logic [NUM_STG-1:0] stg_hit;
    logic               src_live;

    // A source only matters when read and not the hard-wired zero register.
    assign src_live = use_i && (src_i != '0);

    generate
        for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
            // Per-stage destination match.
            assign stg_hit[s] = stg_act_i[s] &&
                                (stg_dst_i[s*REG_W +: REG_W] == src_i);
        end
    endgenerate

    assign hit_o = src_live && (|stg_hit);
endmodule

// File: rtl/hz_raw_detect.sv
// Read-after-write detector over all decode sources.
// Assumes sources are packed with source 0 in the low bits.
module hz_raw_detect #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int NUM_STG = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] src_i,
    input  logic [NUM_SRC-1:0]       src_use_i,
    input  logic [NUM_STG*REG_W-1:0] stg_dst_i,
    input  logic [NUM_STG-1:0]       stg_act_i,
    output logic                     raw_o
);
    logic [NUM_SRC-1:0] src_hit;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            // One comparator per decode source.
            hz_src_cmp #(
                .REG_W   (REG_W),
                .NUM_STG (NUM_STG)
            ) u_cmp (
                .src_i     (src_i[g*REG_W +: REG_W]),
                .use_i     (src_use_i[g]),
                .stg_dst_i (stg_dst_i),
                .stg_act_i (stg_act_i),
                .hit_o     (src_hit[g])
            );
        end
    endgenerate

    assign raw_o = |src_hit;
endmodule

// File: rtl/hz_exc_ctrl.sv
// Produces the single-cycle fetch redirect for an execute exception.
// Assumes the exception flag is synchronous to clk_i; a flag held for
// several cycles yields one redirect in its first cycle only.
module hz_exc_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic exc_i,
    output logic redirect_o
);
    logic exc_d;

    // Remember last cycle's exception flag for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            exc_d <= 1'b0;
        end else begin
            exc_d <= exc_i;
        end
    end

    assign redirect_o = exc_i && !exc_d;
endmodule

// File: rtl/hz_interlock_ctrl.sv
// Hazard control unit for a five-stage in-order pipeline without forwarding.
// Stalls decode on a read-after-write match with execute or memory access,
// injects all-zero bubbles into execute, and on an execute exception kills
// the faulting instruction's writes and flushes younger instructions.
// Assumes register-file write-before-read, so writeback is never compared.
module hz_interlock_ctrl #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int INSTR_W = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [INSTR_W-1:0]       id_instr_i,
    input  logic                     id_rwen_i,
    input  logic                     id_mwen_i,
    input  logic [NUM_SRC*REG_W-1:0] id_src_i,
    input  logic [NUM_SRC-1:0]       id_src_use_i,
    input  logic [REG_W-1:0]         ex_dst_i,
    input  logic                     ex_valid_i,
    input  logic                     ex_rwen_i,
    input  logic                     ex_mwen_i,
    input  logic [REG_W-1:0]         mem_dst_i,
    input  logic                     mem_valid_i,
    input  logic                     mem_rwen_i,
    input  logic                     ex_exc_i,
    output logic                     pc_hold_o,
    output logic                     ifid_hold_o,
    output logic                     ifid_flush_o,
    output logic                     idex_bubble_o,
    output logic [INSTR_W-1:0]       idex_instr_o,
    output logic                     idex_rwen_o,
    output logic                     idex_mwen_o,
    output logic                     ex_rwen_o,
    output logic                     ex_mwen_o,
    output logic                     redirect_o
);
    import hz_pkg::*;

    localparam int NUM_STG = NUM_OLDER;

    logic [NUM_STG*REG_W-1:0] stg_dst;
    logic [NUM_STG-1:0]       stg_act;
    logic                     raw;
    logic                     kill;
    hz_mode_e                 mode;

    // Older stages, execute in slot 0 and memory access in slot 1.
    assign stg_dst = {mem_dst_i, ex_dst_i};
    assign stg_act = {mem_valid_i && mem_rwen_i, ex_valid_i && ex_rwen_i};

    hz_raw_detect #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC),
        .NUM_STG (NUM_STG)
    ) u_raw (
        .src_i     (id_src_i),
        .src_use_i (id_src_use_i),
        .stg_dst_i (stg_dst),
        .stg_act_i (stg_act),
        .raw_o     (raw)
    );

    hz_exc_ctrl u_exc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .exc_i      (ex_exc_i),
        .redirect_o (redirect_o)
    );

    // Pick the cycle's mode; the exception flush outranks a data stall.
    always_comb begin
        if (ex_exc_i) begin
            mode = MODE_FLUSH;
        end else if (raw) begin
            mode = MODE_STALL;
        end else begin
            mode = MODE_RUN;
        end
    end

    // Translate the mode into pipeline register controls.
    always_comb begin
        pc_hold_o     = 1'b0;
        ifid_hold_o   = 1'b0;
        ifid_flush_o  = 1'b0;
        idex_bubble_o = 1'b0;
        kill          = 1'b0;
        case (mode)
            MODE_STALL: begin
                pc_hold_o     = 1'b1;
                ifid_hold_o   = 1'b1;
                idex_bubble_o = 1'b1;
            end
            MODE_FLUSH: begin
                ifid_flush_o  = 1'b1;
                idex_bubble_o = 1'b1;
                kill          = 1'b1;
            end
            default: begin
                pc_hold_o = 1'b0;
            end
        endcase
    end

    // Bubble mux into execute: the no-op is the all-zero word with no writes.
    always_comb begin
        if (idex_bubble_o) begin
            idex_instr_o = '0;
            idex_rwen_o  = 1'b0;
            idex_mwen_o  = 1'b0;
        end else begin
            idex_instr_o = id_instr_i;
            idex_rwen_o  = id_rwen_i;
            idex_mwen_o  = id_mwen_i;
        end
    end

    // Turn the faulting execute instruction into a no-op.
    always_comb begin
        ex_rwen_o = ex_rwen_i && !kill;
        ex_mwen_o = ex_mwen_i && !kill;
    end
endmodule

// File: rtl/hz_interlock_chk.sv
// Property checker for hz_interlock_ctrl, attached with bind below.
module hz_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int INSTR_W = 32
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_SRC*REG_W-1:0] id_src_i,
    input logic [NUM_SRC-1:0]       id_src_use_i,
    input logic [REG_W-1:0]         ex_dst_i,
    input logic                     ex_valid_i,
    input logic                     ex_rwen_i,
    input logic                     ex_exc_i,
    input logic                     pc_hold_o,
    input logic                     ifid_hold_o,
    input logic                     ifid_flush_o,
    input logic                     idex_bubble_o,
    input logic [INSTR_W-1:0]       idex_instr_o,
    input logic                     idex_rwen_o,
    input logic                     idex_mwen_o,
    input logic                     ex_rwen_o,
    input logic                     ex_mwen_o,
    input logic                     redirect_o
);
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assert_raw_ex_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!ex_exc_i && id_src_use_i[g] && ex_valid_i && ex_rwen_i &&
                 (id_src_i[g*REG_W +: REG_W] != '0) &&
                 (id_src_i[g*REG_W +: REG_W] == ex_dst_i)) |-> pc_hold_o);
        end
    endgenerate

    assert_stall_coherent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_hold_o |-> (ifid_hold_o && idex_bubble_o));

    assert_unused_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_src_use_i == '0) |-> !pc_hold_o);

    assert_bubble_nop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idex_bubble_o |-> ((idex_instr_o == '0) && !idex_rwen_o && !idex_mwen_o));

    assert_exc_kill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ex_exc_i |-> (!ex_rwen_o && !ex_mwen_o && ifid_flush_o && idex_bubble_o));

    assert_exc_no_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ex_exc_i |-> (!pc_hold_o && !ifid_hold_o));

    assert_redirect_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> !redirect_o);

    assert_redirect_needs_exc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> ex_exc_i);

    assert_no_spurious_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ex_exc_i |-> !ifid_flush_o);
endmodule

bind hz_interlock_ctrl hz_interlock_chk #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC),
    .INSTR_W (INSTR_W)
) u_chk (.*);

// File: tb/hz_interlock_ctrl_test.sv
// Self-checking bench: models the pipeline registers around the controller.
module hz_interlock_ctrl_test;
    localparam int HANDLER = 24;
    localparam int PLEN    = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] id_instr;
    logic        id_rwen, id_mwen;
    logic [9:0]  id_src;
    logic [1:0]  id_src_use;
    logic [4:0]  ex_dst, mem_dst;
    logic        ex_valid, ex_rwen, ex_mwen, mem_valid, mem_rwen, ex_exc;
    logic        pc_hold, ifid_hold, ifid_flush, idex_bubble;
    logic [31:0] idex_instr;
    logic        idex_rwen, idex_mwen, ex_rwen_q, ex_mwen_q, redirect;

    always #10 clk = ~clk;   // 50 MHz

    hz_interlock_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n),
        .id_instr_i(id_instr), .id_rwen_i(id_rwen), .id_mwen_i(id_mwen),
        .id_src_i(id_src), .id_src_use_i(id_src_use),
        .ex_dst_i(ex_dst), .ex_valid_i(ex_valid), .ex_rwen_i(ex_rwen), .ex_mwen_i(ex_mwen),
        .mem_dst_i(mem_dst), .mem_valid_i(mem_valid), .mem_rwen_i(mem_rwen),
        .ex_exc_i(ex_exc),
        .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .ifid_flush_o(ifid_flush),
        .idex_bubble_o(idex_bubble), .idex_instr_o(idex_instr),
        .idex_rwen_o(idex_rwen), .idex_mwen_o(idex_mwen),
        .ex_rwen_o(ex_rwen_q), .ex_mwen_o(ex_mwen_q), .redirect_o(redirect)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] prog [0:PLEN-1];
    int pc, id_idx, ex_idx, mm_idx, wb_idx;
    logic [31:0] id_w, ex_w, mm_w;
    logic ex_rw, ex_mw, mm_rw, mm_mw, wb_rw;
    int exc_at, cyc, stall_cnt, flush_cnt, watch_idx, watch_cyc;
    bit wrote [0:PLEN-1];
    bit mwrote [0:PLEN-1];

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {op, rs, rt, rd, 11'd0};
    endfunction
    function automatic logic [4:0] f_rs(logic [31:0] w); return w[25:21]; endfunction
    function automatic logic [4:0] f_rt(logic [31:0] w); return w[20:16]; endfunction
    function automatic logic [4:0] f_rd(logic [31:0] w); return w[15:11]; endfunction
    function automatic logic f_rwen(logic [31:0] w); return (w != 0) && (w[31:26] == 6'h00); endfunction
    function automatic logic f_mwen(logic [31:0] w); return w[31:26] == 6'h2b; endfunction
    function automatic logic f_hit(logic [4:0] src, logic use_src, logic [4:0] dst, logic act);
        return use_src && (src != 0) && act && (src == dst);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        pc = 0; id_idx = -1; ex_idx = -1; mm_idx = -1; wb_idx = -1;
        id_w = 0; ex_w = 0; mm_w = 0;
        ex_rw = 0; ex_mw = 0; mm_rw = 0; mm_mw = 0; wb_rw = 0;
        cyc = 0; stall_cnt = 0; flush_cnt = 0; watch_cyc = -1;
        for (int i = 0; i < PLEN; i++) begin wrote[i] = 0; mwrote[i] = 0; end
    endtask

    task automatic load_nops();
        for (int i = 0; i < PLEN; i++) prog[i] = 32'd0;
    endtask

    // One pipeline cycle: drive, sample, compare, then advance the model.
    task automatic step();
        logic raw_e, stall_e;
        @(negedge clk);
        cyc++;
        id_instr   = id_w;
        id_src     = {f_rt(id_w), f_rs(id_w)};
        id_src_use = {2{id_w != 0}};
        id_rwen    = f_rwen(id_w);
        id_mwen    = f_mwen(id_w);
        ex_dst     = f_rd(ex_w);
        ex_valid   = ex_idx >= 0;
        ex_rwen    = ex_rw;
        ex_mwen    = ex_mw;
        mem_dst    = f_rd(mm_w);
        mem_valid  = mm_idx >= 0;
        mem_rwen   = mm_rw;
        ex_exc     = (ex_idx >= 0) && (ex_idx == exc_at);
        if (ex_idx == watch_idx && watch_cyc < 0) watch_cyc = cyc;
        #2;
        raw_e = f_hit(f_rs(id_w), id_w != 0, ex_dst, ex_valid && ex_rwen) ||
                f_hit(f_rt(id_w), id_w != 0, ex_dst, ex_valid && ex_rwen) ||
                f_hit(f_rs(id_w), id_w != 0, mem_dst, mem_valid && mem_rwen) ||
                f_hit(f_rt(id_w), id_w != 0, mem_dst, mem_valid && mem_rwen);
        stall_e = raw_e && !ex_exc;
        check(pc_hold == stall_e, "R1 pc_hold", pc_hold, stall_e);
        check(ifid_hold == stall_e, "R1 ifid_hold", ifid_hold, stall_e);
        check(idex_bubble == (stall_e || ex_exc), "R4 bubble", idex_bubble, stall_e || ex_exc);
        if (idex_bubble)
            check(idex_instr == 0 && !idex_rwen && !idex_mwen, "R4 nop word", idex_instr, 0);
        else
            check(idex_instr == id_w && idex_rwen == f_rwen(id_w), "R4 pass", idex_instr, id_w);
        check(ifid_flush == ex_exc, "R8 flush", ifid_flush, ex_exc);
        check(ex_rwen_q == (ex_rw && !ex_exc), "R5 ex rwen", ex_rwen_q, ex_rw && !ex_exc);
        check(ex_mwen_q == (ex_mw && !ex_exc), "R5 ex mwen", ex_mwen_q, ex_mw && !ex_exc);
        check(redirect == ex_exc, "R7 redirect", redirect, ex_exc);
        if (pc_hold) stall_cnt++;
        if (ifid_flush) flush_cnt++;
        if (wb_rw && wb_idx >= 0) wrote[wb_idx] = 1;
        if (mm_mw && mm_idx >= 0) mwrote[mm_idx] = 1;
        // advance model registers
        wb_idx = mm_idx; wb_rw = mm_rw;
        mm_idx = ex_idx; mm_w = ex_w; mm_rw = ex_rwen_q; mm_mw = ex_mwen_q;
        ex_idx = idex_bubble ? -1 : id_idx;
        ex_w = idex_instr; ex_rw = idex_rwen; ex_mw = idex_mwen;
        if (ifid_flush) begin
            id_w = 0; id_idx = -1;
        end else if (!ifid_hold) begin
            id_w = prog[pc]; id_idx = pc;
        end
        if (redirect) pc = HANDLER;
        else if (!pc_hold && pc < PLEN-1) pc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic idle_inputs();
        id_instr = 0; id_rwen = 0; id_mwen = 0; id_src = 0; id_src_use = 0;
        ex_dst = 0; ex_valid = 0; ex_rwen = 0; ex_mwen = 0;
        mem_dst = 0; mem_valid = 0; mem_rwen = 0; ex_exc = 0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        // R9: idle after reset
        check({pc_hold, ifid_hold, ifid_flush, idex_bubble, redirect, ex_rwen_q, ex_mwen_q} == 0,
              "R9 reset idle", {pc_hold, ifid_hold, ifid_flush, idex_bubble, redirect}, 0);

        // R6/R7: held exception with a simultaneous hazard
        @(negedge clk);
        id_src = {5'd3, 5'd7}; id_src_use = 2'b11; id_rwen = 1;
        ex_dst = 5'd7; ex_valid = 1; ex_rwen = 1; ex_mwen = 1; ex_exc = 1;
        #2;
        check(!pc_hold && !ifid_hold, "R6 exc beats stall", pc_hold, 0);
        check(redirect == 1, "R7 first exc cycle", redirect, 1);
        check(!ex_rwen_q && !ex_mwen_q, "R5 kill", ex_rwen_q, 0);
        @(negedge clk); #2;
        check(redirect == 0, "R7 held exc no repeat", redirect, 0);
        check(ifid_flush == 1, "R5 flush held", ifid_flush, 1);
        @(negedge clk); ex_exc = 0; #2;
        check(pc_hold == 1 && idex_bubble == 1, "R1 stall after exc", pc_hold, 1);
        check(redirect == 0, "R7 no exc", redirect, 0);
        // R3: unused sources, register zero
        @(negedge clk); id_src_use = 2'b00; #2;
        check(pc_hold == 0, "R3 unused src", pc_hold, 0);
        @(negedge clk); id_src = 10'd0; id_src_use = 2'b11; ex_dst = 5'd0; #2;
        check(pc_hold == 0, "R3 zero reg", pc_hold, 0);
        @(negedge clk); idle_inputs(); mem_dst = 5'd4; mem_valid = 1; mem_rwen = 1;
        id_src = {5'd0, 5'd4}; id_src_use = 2'b01; #2;
        check(pc_hold == 1, "R1 mem match", pc_hold, 1);
        @(negedge clk); idle_inputs();

        // R2: add then dependent sub
        load_nops(); model_reset(); exc_at = -1; watch_idx = 1;
        prog[0] = mk(6'h00, 5'd9, 5'd9, 5'd8);
        prog[1] = mk(6'h00, 5'd8, 5'd8, 5'd10);
        run(10);
        check(watch_cyc == 6, "R2 sub enters EX cycle", watch_cyc, 6);
        check(stall_cnt == 2, "R2 bubble count", stall_cnt, 2);
        check(wrote[0] && wrote[1], "R2 both retire", wrote[1], 1);

        // R10/R8: independent mix with branch and delay slot
        load_nops(); model_reset(); exc_at = -1; watch_idx = 2;
        prog[0] = mk(6'h00, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(6'h04, 5'd4, 5'd5, 5'd0);
        prog[2] = mk(6'h00, 5'd6, 5'd7, 5'd11);
        prog[3] = mk(6'h2b, 5'd12, 5'd13, 5'd0);
        prog[4] = mk(6'h00, 5'd14, 5'd15, 5'd16);
        prog[5] = mk(6'h00, 5'd3, 5'd1, 5'd17);
        run(12);
        check(stall_cnt == 0, "R10 no stall", stall_cnt, 0);
        check(flush_cnt == 0, "R8 no flush", flush_cnt, 0);
        check(watch_cyc == 5, "R8 delay slot in EX", watch_cyc, 5);
        check(mwrote[3] == 1, "R10 store reaches MEM", mwrote[3], 1);

        // R3: reads of register zero after a write to it
        load_nops(); model_reset(); exc_at = -1; watch_idx = -2;
        prog[0] = mk(6'h00, 5'd1, 5'd1, 5'd0);
        prog[1] = mk(6'h00, 5'd0, 5'd0, 5'd5);
        run(8);
        check(stall_cnt == 0, "R3 zero reg pipeline", stall_cnt, 0);

        // R5: exception in EX suppresses younger writes
        load_nops(); model_reset(); exc_at = 2; watch_idx = -2;
        prog[0] = mk(6'h00, 5'd1, 5'd1, 5'd2);
        prog[1] = mk(6'h00, 5'd3, 5'd3, 5'd4);
        prog[2] = mk(6'h00, 5'd5, 5'd5, 5'd6);
        prog[3] = mk(6'h00, 5'd7, 5'd7, 5'd8);
        prog[4] = mk(6'h2b, 5'd9, 5'd9, 5'd0);
        prog[5] = mk(6'h00, 5'd10, 5'd10, 5'd12);
        prog[HANDLER] = mk(6'h00, 5'd20, 5'd20, 5'd21);
        run(12);
        check(wrote[0] && wrote[1], "R5 older retire", wrote[1], 1);
        for (int i = 2; i < 6; i++) begin
            check(!wrote[i] && !mwrote[i], "R5 younger no write", i, -1);
        end
        check(wrote[HANDLER] == 1, "R7 handler fetched", wrote[HANDLER], 1);
        check(flush_cnt == 1, "R5 one flush", flush_cnt, 1);

        // Random programs with dense register reuse
        for (int p = 0; p < 60; p++) begin
            load_nops(); model_reset(); watch_idx = -2;
            exc_at = ($urandom % 3 == 0) ? int'($urandom % 12) : -1;
            for (int i = 0; i < 16; i++) begin
                int r;
                logic [5:0] op;
                r = $urandom % 10;
                op = (r < 7) ? 6'h00 : (r < 9) ? 6'h2b : 6'h04;
                prog[i] = mk(op, 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
            end
            run(30);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule